// File: doc/BRIEF.md
# Channel Status Block Double Buffer

This block keeps one complete block of channel status bits, 192 frames long, for both subframes (channel A and channel B) of an AES3-style audio stream. A receive-side capture buffer collects one status bit per channel per frame as frames arrive, aligned to a block-start marker. A transmit-side buffer supplies the status bit for each outgoing frame and flags the first frame of every block. When a received block is complete, a block copy moves it into the transmit buffer. The copy waits for the transmit side to finish the block it is sending, so a block that is on the wire is never changed part way through.

A host reaches the transmit buffer through a byte port of 24 addresses per channel. In paired mode one access carries the channel A byte and the channel B byte together. In single mode a select input picks the channel. The first five bytes can be reserved for host writes, so block copies leave them alone. When the transmitted block is marked professional (bit 0 of byte 0 set), the block computes a CRC-8 over the block itself and sends it in place of the last byte.

Top module: `chstat_dbuf`

## Requirements
- R1: After reset the transmit buffer holds all zeros, the host read data is zero, both transmit bits are 0, the block-start output is high (frame 0) and no copy is pending.
- R2: Capture starts only at a frame with `rx_start` high. Frames with `rx_valid` high before the first start marker are ignored and never complete a block.
- R3: When a captured block completes (frame 191 written) with copy enabled, a copy is held pending. It takes place on the `tx_step` that advances the transmit side from frame 191 to frame 0. Until then, host reads and transmit bits show the old contents. The copy takes the capture buffer contents at that moment.
- R4: With `protect_en` high, a block copy leaves bytes 0 to 4 of both channels unchanged and copies bytes 5 to 23.
- R5: With `two_byte` high, a read returns the channel A byte in `host_rdata[15:8]` and the channel B byte in `host_rdata[7:0]`. A write stores `host_wdata[15:8]` into channel A and `host_wdata[7:0]` into channel B.
- R6: With `two_byte` low, `chan_sel` = 0 selects channel A and 1 selects channel B. A read returns the selected byte in `host_rdata[7:0]` with `host_rdata[15:8]` = 0. A write stores `host_wdata[7:0]` into the selected channel only.
- R7: Transmit frame k (0 to 191) carries bit k mod 8 of byte k/8 of each channel, least significant bit first. `tx_blk_start` is high during frame 0 only, and each `tx_step` advances one frame, wrapping after 191.
- R8: If bit 0 of byte 0 of a channel is 1 when frame 0 is stepped, frames 184 to 191 of that channel carry CRC bits 0 to 7 in place of byte 23. The CRC starts from 0xFF and takes the bits of bytes 0 to 22 in transmit order. For each bit, the feedback is the bit XOR CRC bit 7, the CRC shifts left one place, and 0x1D is XORed in when the feedback is 1. Host reads of byte 23 return the stored byte.
- R9: With `xfer_en` low, completed blocks set no pending copy and the transmit buffer changes only by host writes.
- R10: A start marker in the middle of a block restarts capture at frame 0. Only a full 192-frame run from the last marker completes a block.
- R11: Host writes to addresses 24 to 31 are ignored, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received frame's status bits are present |
| rx_start | input | 1 | This received frame is frame 0 of a block |
| rx_bit_a | input | 1 | Received channel A status bit |
| rx_bit_b | input | 1 | Received channel B status bit |
| tx_step | input | 1 | Advance the transmit side by one frame |
| tx_bit_a | output | 1 | Channel A status bit for the current transmit frame |
| tx_bit_b | output | 1 | Channel B status bit for the current transmit frame |
| tx_blk_start | output | 1 | High while the current transmit frame is frame 0 |
| xfer_en | input | 1 | Allow completed blocks to be copied to the transmit buffer |
| protect_en | input | 1 | Keep bytes 0 to 4 out of block copies |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 5 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| two_byte | input | 1 | Paired A/B access mode |
| chan_sel | input | 1 | Channel select in single mode |

## Verification
The hardest situation to reach from the ports is a copy that is pending while a transmit block is still in progress. The bench completes a captured block with the transmit side at frame 0. It then reads the old contents back, steps the transmit side through a whole block, and reads again after the wrap. Protection, copies with the enable off and the mid-block realignment are all driven this way. Each outcome is then read back over the host port and seen on the transmitted bits. The CRC path is reached by writing a professional marker into byte 0 over the host port before a block is transmitted.

// File: rtl/chstat_pkg.sv
// Shared constants and helpers for the channel status double buffer.
// Assumes two subframe channels and a CRC one byte wide.
package chstat_pkg;
    localparam int CS_NCH        = 2;
    localparam int CS_BYTE_W     = 8;
    localparam int CS_FRAMES     = 192;
    localparam int CS_PROT_BYTES = 5;
    localparam logic [7:0] CS_CRC_POLY = 8'h1D;
    localparam logic [7:0] CS_CRC_INIT = 8'hFF;

    // One serial CRC-8 update: feedback from MSB, shift left.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        fb = b ^ c[7];
        return {c[6:0], 1'b0} ^ (fb ? CS_CRC_POLY : 8'h00);
    endfunction
endpackage

// File: rtl/chstat_rx_capture.sv
// Receive-side capture buffer: one status bit per channel per frame,
// aligned to a start marker. Assumes at most one frame per clock.
// Bits seen before the first marker are dropped.
module chstat_rx_capture #(
    parameter int FRAMES = chstat_pkg::CS_FRAMES,
    parameter int NCH    = chstat_pkg::CS_NCH,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_start,
    input  logic [NCH-1:0]    rx_bits,
    output logic [FRAMES-1:0] d_q [NCH],
    output logic              d_done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

    logic [IDX_W-1:0] idx;
    logic             synced;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_en;

    assign wr_idx = rx_start ? '0 : idx;
    assign wr_en  = rx_valid && (rx_start || synced);
    assign d_done = wr_en && (wr_idx == LAST);

    // Frame position counter and alignment flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            synced <= 1'b0;
        end else if (wr_en) begin
            idx    <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
            synced <= 1'b1;
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // Store the received bit at its frame position.
        always_ff @(posedge clk) begin
            if (!rst_n) d_q[ch] <= '0;
            else if (wr_en) d_q[ch][wr_idx] <= rx_bits[ch];
        end
    end

    // R10: a start marker always places the next frame at position 1
    a_r10_realign: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_start |=> idx == IDX_W'(1));
endmodule

// File: rtl/chstat_tx_engine.sv
// Transmit-side sequencer: walks frames 0..FRAMES-1, emits one bit per
// channel, flags frame 0 and substitutes a serial CRC in the last byte
// of professional blocks. Assumes the buffer holds still within a block.
module chstat_tx_engine #(
    parameter int FRAMES = chstat_pkg::CS_FRAMES,
    parameter int NCH    = chstat_pkg::CS_NCH,
    localparam int IDX_W = $clog2(FRAMES),
    localparam int CRC_START = FRAMES - chstat_pkg::CS_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_step,
    input  logic [FRAMES-1:0] e_q [NCH],
    output logic [NCH-1:0]    tx_bits,
    output logic              tx_blk_start,
    output logic              tx_wrap
);
    import chstat_pkg::*;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);
    localparam logic [IDX_W-1:0] CRC_FIRST = IDX_W'(CRC_START);

    logic [IDX_W-1:0] idx;
    logic             in_crc;
    logic [2:0]       crc_pos;
    logic [7:0]       crc_q [NCH];
    logic             pro_q [NCH];

    assign tx_blk_start = (idx == '0);
    assign tx_wrap      = tx_step && (idx == LAST);
    assign in_crc       = (idx >= CRC_FIRST);
    assign crc_pos      = 3'(idx - CRC_FIRST);

    // Transmit frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n) idx <= '0;
        else if (tx_step) idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // Latch the professional flag at frame 0 and run the serial CRC.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                crc_q[ch] <= CS_CRC_INIT;
                pro_q[ch] <= 1'b0;
            end else if (tx_step && !in_crc) begin
                crc_q[ch] <= crc8_step(tx_blk_start ? CS_CRC_INIT : crc_q[ch], e_q[ch][idx]);
                if (tx_blk_start) pro_q[ch] <= e_q[ch][0];
            end
        end

        assign tx_bits[ch] = (in_crc && pro_q[ch]) ? crc_q[ch][crc_pos] : e_q[ch][idx];

        // R8: the CRC does not move while its bits are being sent
        a_r8_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            tx_step && in_crc |=> $stable(crc_q[ch]));
    end

    // R7: block start lasts exactly one frame
    a_r7_blk_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_step && tx_blk_start |=> !tx_blk_start);
endmodule

// File: rtl/chstat_ebuf.sv
// Transmit buffer with host byte port and deferred block copy.
// Assumes the copy trigger comes from the transmit wrap, so a copy only
// lands between blocks. Host writes win over a copy on the same byte.
module chstat_ebuf #(
    parameter int FRAMES     = chstat_pkg::CS_FRAMES,
    parameter int NCH        = chstat_pkg::CS_NCH,
    parameter int PROT_BYTES = chstat_pkg::CS_PROT_BYTES,
    localparam int BYTES     = FRAMES / chstat_pkg::CS_BYTE_W,
    localparam int ADDR_W    = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAMES-1:0] d_q [NCH],
    input  logic              d_done,
    input  logic              tx_wrap,
    input  logic              xfer_en,
    input  logic              protect_en,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    input  logic              two_byte,
    input  logic              chan_sel,
    output logic [FRAMES-1:0] e_q [NCH],
    output logic [15:0]       host_rdata
);
    localparam int BW = chstat_pkg::CS_BYTE_W;

    logic       pending;
    logic       xfer_go;
    logic       addr_ok;
    logic [7:0] rbyte [NCH];
    logic [7:0] wbyte [NCH];
    logic       wr_hit [NCH];

    assign xfer_go = tx_wrap && pending && xfer_en;
    assign addr_ok = (host_addr < ADDR_W'(BYTES));

    // Hold a completed block until the transmit side wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else if (d_done && xfer_en) pending <= 1'b1;
        else if (xfer_go) pending <= 1'b0;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [BW-1:0] view [BYTES];
        for (genvar b = 0; b < BYTES; b++) begin : g_view
            assign view[b] = e_q[ch][b*BW +: BW];
        end

        assign wbyte[ch]  = (two_byte && ch == 0) ? host_wdata[15:8] : host_wdata[7:0];
        assign wr_hit[ch] = host_wr && addr_ok && (two_byte || (chan_sel == 1'(ch)));
        assign rbyte[ch]  = addr_ok ? view[host_addr] : '0;

        // Block copy (skipping protected bytes), then host write on top.
        always_ff @(posedge clk) begin
            if (!rst_n) e_q[ch] <= '0;
            else begin
                for (int b = 0; b < BYTES; b++) begin
                    if (xfer_go && !(protect_en && b < PROT_BYTES))
                        e_q[ch][b*BW +: BW] <= d_q[ch][b*BW +: BW];
                    if (wr_hit[ch] && host_addr == ADDR_W'(b))
                        e_q[ch][b*BW +: BW] <= wbyte[ch];
                end
            end
        end

        // R4: protected bytes change only through the host
        a_r4_protected_stable: assert property (@(posedge clk) disable iff (!rst_n)
            protect_en && !host_wr |=> $stable(e_q[ch][PROT_BYTES*BW-1:0]));
        // R9: with copying off the buffer changes only through the host
        a_r9_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
            !xfer_en && !host_wr |=> $stable(e_q[ch]));
    end

    assign host_rdata = two_byte ? {rbyte[0], rbyte[1]} : {8'h00, rbyte[chan_sel]};

    // R3: a pending copy is only consumed on a transmit wrap
    a_r3_fire_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(tx_wrap));
endmodule

// File: rtl/chstat_dbuf.sv
// Top of the channel status double buffer: capture buffer, transmit
// buffer with host port, and transmit sequencer with CRC insertion.
// Assumes one clock domain for receive, transmit and host sides.
module chstat_dbuf #(
    parameter int FRAMES     = chstat_pkg::CS_FRAMES,
    parameter int PROT_BYTES = chstat_pkg::CS_PROT_BYTES,
    localparam int ADDR_W    = $clog2(FRAMES / chstat_pkg::CS_BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_start,
    input  logic              rx_bit_a,
    input  logic              rx_bit_b,
    input  logic              tx_step,
    output logic              tx_bit_a,
    output logic              tx_bit_b,
    output logic              tx_blk_start,
    input  logic              xfer_en,
    input  logic              protect_en,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic              two_byte,
    input  logic              chan_sel
);
    localparam int NCH = chstat_pkg::CS_NCH;

    logic [FRAMES-1:0] d_q [NCH];
    logic [FRAMES-1:0] e_q [NCH];
    logic              d_done;
    logic              tx_wrap;
    logic [NCH-1:0]    tx_bits;

    chstat_rx_capture #(.FRAMES(FRAMES), .NCH(NCH)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_start(rx_start),
        .rx_bits({rx_bit_b, rx_bit_a}), .d_q(d_q), .d_done(d_done));

    chstat_ebuf #(.FRAMES(FRAMES), .NCH(NCH), .PROT_BYTES(PROT_BYTES)) u_eb (
        .clk(clk), .rst_n(rst_n), .d_q(d_q), .d_done(d_done), .tx_wrap(tx_wrap),
        .xfer_en(xfer_en), .protect_en(protect_en), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .two_byte(two_byte),
        .chan_sel(chan_sel), .e_q(e_q), .host_rdata(host_rdata));

    chstat_tx_engine #(.FRAMES(FRAMES), .NCH(NCH)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_step(tx_step), .e_q(e_q),
        .tx_bits(tx_bits), .tx_blk_start(tx_blk_start), .tx_wrap(tx_wrap));

    assign tx_bit_a = tx_bits[0];
    assign tx_bit_b = tx_bits[1];
endmodule

// File: tb/sim_chstat_dbuf.sv
// Directed bench for the channel status double buffer.
module sim_chstat_dbuf;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, rx_valid, rx_start, rx_bit_a, rx_bit_b, tx_step;
    logic tx_bit_a, tx_bit_b, tx_blk_start, xfer_en, protect_en, host_wr;
    logic [4:0] host_addr;
    logic [15:0] host_wdata, host_rdata;
    logic two_byte, chan_sel;

    chstat_dbuf u0 (.*);

    int n_cmp = 0, n_bad = 0;
    logic [7:0] ma[24], mb[24], da[24], db[24], ra[24], rb[24];
    logic pend_m = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_m(input logic [7:0] by[24]);
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < 23; i++)
            for (int j = 0; j < 8; j++) begin
                logic fb = by[i][j] ^ c[7];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
            end
        return c;
    endfunction

    task automatic host_write(input int addr, input logic [15:0] d, input logic two, input logic sel);
        @(negedge clk);
        host_wr = 1; host_addr = 5'(addr); host_wdata = d; two_byte = two; chan_sel = sel;
        @(negedge clk);
        host_wr = 0;
        if (addr < 24) begin
            if (two) begin ma[addr] = d[15:8]; mb[addr] = d[7:0]; end
            else if (sel) mb[addr] = d[7:0];
            else ma[addr] = d[7:0];
        end
    endtask

    task automatic host_check(input string req, input int addr, input logic two, input logic sel);
        logic [15:0] exp;
        host_addr = 5'(addr); two_byte = two; chan_sel = sel;
        #2;
        if (addr >= 24) exp = 16'h0;
        else if (two) exp = {ma[addr], mb[addr]};
        else exp = {8'h00, sel ? mb[addr] : ma[addr]};
        check(req, 32'(host_rdata), 32'(exp));
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 24; i++) host_check(req, i, 1'b1, 1'b0);
    endtask

    task automatic rx_send(input int nbits, input logic with_start);
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            rx_valid = 1; rx_start = with_start && (k == 0);
            rx_bit_a = ra[k/8][k%8]; rx_bit_b = rb[k/8][k%8];
        end
        @(negedge clk);
        rx_valid = 0; rx_start = 0;
    endtask

    task automatic rx_block();
        rx_send(192, 1'b1);
        for (int i = 0; i < 24; i++) begin da[i] = ra[i]; db[i] = rb[i]; end
        if (xfer_en) pend_m = 1'b1;
    endtask

    // Transmit one block from frame 0, check every frame, then model the wrap.
    task automatic tx_block(input string req);
        logic [7:0] ca = crc_m(ma), cb = crc_m(mb);
        logic pa = ma[0][0], pb = mb[0][0];
        for (int k = 0; k < 192; k++) begin
            logic ea, eb;
            @(negedge clk);
            ea = (k >= 184 && pa) ? ca[k-184] : ma[k/8][k%8];
            eb = (k >= 184 && pb) ? cb[k-184] : mb[k/8][k%8];
            check({req, " bit A"}, 32'(tx_bit_a), 32'(ea));
            check({req, " bit B"}, 32'(tx_bit_b), 32'(eb));
            check("R7 block start", 32'(tx_blk_start), 32'(k == 0));
            tx_step = 1;
        end
        @(negedge clk);
        tx_step = 0;
        if (pend_m && xfer_en) begin
            for (int i = 0; i < 24; i++)
                if (!(protect_en && i < 5)) begin ma[i] = da[i]; mb[i] = db[i]; end
            pend_m = 0;
        end
    endtask

    task automatic fill_rx(input logic [7:0] sa, input logic [7:0] sb);
        for (int i = 0; i < 24; i++) begin ra[i] = sa + 8'(i * 7); rb[i] = sb ^ 8'(i * 13); end
    endtask

    task automatic t_reset();
        for (int i = 0; i < 24; i++) begin ma[i] = 0; mb[i] = 0; end
        host_check("R1 rdata", 0, 1'b1, 1'b0);
        check("R1 blk_start", 32'(tx_blk_start), 32'd1);
        check("R1 tx_bit_a", 32'(tx_bit_a), 32'd0);
        check("R1 tx_bit_b", 32'(tx_bit_b), 32'd0);
    endtask

    task automatic t_presync();
        fill_rx(8'hFF, 8'hFF);
        for (int i = 0; i < 24; i++) begin ra[i] = 8'hFF; rb[i] = 8'hFF; end
        rx_send(192, 1'b0);
        tx_block("R2");
        host_check("R2 unsynced ignored", 7, 1'b1, 1'b0);
    endtask

    task automatic t_host_two();
        for (int i = 0; i < 24; i++)
            host_write(i, {8'(8'h40 + i * 3), 8'(8'hC2 ^ (i * 5))}, 1'b1, 1'b0);
        host_check("R5 pair read", 0, 1'b1, 1'b0);
        host_check("R5 pair read", 11, 1'b1, 1'b0);
        host_check("R5 pair read", 23, 1'b1, 1'b0);
        tx_block("R7");
    endtask

    task automatic t_one_byte();
        host_write(3, 16'hFF5A, 1'b0, 1'b1);
        host_check("R6 read A", 3, 1'b0, 1'b0);
        host_check("R6 read B", 3, 1'b0, 1'b1);
        host_check("R6 pair after single write", 3, 1'b1, 1'b0);
        host_write(9, 16'h77A5, 1'b0, 1'b0);
        host_check("R6 write A only", 9, 1'b1, 1'b0);
    endtask

    task automatic t_range();
        host_write(24, 16'hDEAD, 1'b1, 1'b0);
        host_write(31, 16'hBEEF, 1'b1, 1'b0);
        host_check("R11 read 24", 24, 1'b1, 1'b0);
        host_check("R11 read 31", 31, 1'b1, 1'b0);
        check_all("R11 buffer intact");
    endtask

    task automatic t_xfer();
        fill_rx(8'h12, 8'h34);
        rx_block();
        host_check("R3 old before wrap", 10, 1'b1, 1'b0);
        tx_block("R3 old block");
        host_check("R3 new after wrap", 10, 1'b1, 1'b0);
        host_check("R3 new after wrap", 2, 1'b1, 1'b0);
        tx_block("R3 new block");
    endtask

    task automatic t_protect();
        protect_en = 1;
        fill_rx(8'h81, 8'h6C);
        rx_block();
        tx_block("R4 old block");
        check_all("R4 protect");
        protect_en = 0;
    endtask

    task automatic t_xfer_off();
        xfer_en = 0;
        fill_rx(8'h5E, 8'h09);
        rx_block();
        tx_block("R9");
        check_all("R9 no copy");
        xfer_en = 1;
    endtask

    task automatic t_realign();
        fill_rx(8'hE3, 8'h1B);
        rx_send(100, 1'b1);
        fill_rx(8'h2A, 8'hD0);
        rx_block();
        tx_block("R10 old block");
        check_all("R10 realigned block");
    endtask

    task automatic t_crc();
        host_write(0, 16'h0005, 1'b0, 1'b0);
        host_write(0, 16'h0004, 1'b0, 1'b1);
        host_write(23, 16'h0066, 1'b0, 1'b0);
        tx_block("R8 crc A");
        host_check("R8 stored byte 23", 23, 1'b0, 1'b0);
        host_write(0, 16'h0001, 1'b0, 1'b1);
        tx_block("R8 crc both");
        host_write(0, 16'h0000, 1'b1, 1'b0);
        tx_block("R8 crc off");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; rx_valid = 0; rx_start = 0; rx_bit_a = 0; rx_bit_b = 0;
        tx_step = 0; xfer_en = 1; protect_en = 0; host_wr = 0; host_addr = 0;
        host_wdata = 0; two_byte = 1; chan_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_presync();
        t_host_two();
        t_one_byte();
        t_range();
        t_xfer();
        t_protect();
        t_xfer_off();
        t_realign();
        t_crc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule